// File: doc/BRIEF.md
# Indirect Bus Cycle Register Controller

This block is a memory-mapped register front end through which a host starts one read or one write cycle on an external peripheral bus. The host programs a target address, write data and a control word holding a direction flag and active-low byte enables. It then sets a start bit. The block offers the cycle to a generic external-cycle engine over a valid/ready request channel and waits for a one-cycle completion pulse. It captures returned read data, reports pending and done status, and raises an interrupt when the cycle completes.

The request channel follows valid/ready rules. Once `req_valid` rises, it stays high, and the address, direction, byte-enable and data fields stay unchanged, until the cycle in which `req_ready` is also high. The start bit clears on that handshake edge. The completion channel has no back-pressure: the block always accepts `resp_valid`. Host register accesses are plain. A write is one cycle of `reg_wr`, and read data is a combinational function of `reg_addr`.

Top module: `ibc_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `req_valid` is low.
- R2: Register word offsets are: 0x00 target address, 0x04 write data, 0x08 read data (read-only), 0x0C control/status, 0x10 interrupt enable (bit 0), and 0x14 interrupt clear (write-only, any write, reads zero). The address register changes only on a write with all four byte strobes set; any other strobe pattern leaves it unchanged.
- R3: `req_addr` carries address register bits 31:2, and its bits 1:0 come from the active (zero) byte enables, not from the register. One active lane gives that lane's index. Lanes 1:0 active give 0. Lanes 3:2 active give 2. All four active gives 0. Any other pattern, including none active, gives 0.
- R4: Control bits 3:0 are the active-low byte enables and bit 4 is the direction (1 read, 0 write). They drive `req_ben_n` and `req_rd`.
- R5: Writing 1 to control bit 7 (start), with byte strobe 0 set, raises `req_valid` from the next cycle. Bit 7 reads 1 and the request fields stay stable until the handshake. On the handshake edge bit 7 clears and `req_valid` falls.
- R6: Control bit 9 (pending) reads 1 from the start write until the edge that accepts `resp_valid`. On that edge bit 9 clears and bit 8 (done) sets. Pending and done are never both 1.
- R7: Done clears on a control write with bit 6 set (bit 6 reads 0), on any write to the interrupt clear register, or on an accepted start. If a completion arrives in the same cycle, completion wins.
- R8: A read cycle's completion loads `resp_rdata` into the read-data register. A write cycle's completion leaves that register unchanged.
- R9: While pending is 1, the block ignores host writes to the address, write-data and control fields, including a new start.
- R10: `irq` is high exactly when done is 1 and interrupt enable bit 0 is 1.
- R11: A `resp_valid` pulse while no launched cycle is pending changes neither done nor the read-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | RAW (5) | Host register byte offset |
| reg_be | input | BEN_W (4) | Host write byte strobes |
| reg_wdata | input | DATA_W (32) | Host write data |
| reg_rdata | output | DATA_W (32) | Host read data for `reg_addr` |
| req_valid | output | 1 | External cycle request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_addr | output | ADDR_W (32) | Cycle address with low bits from byte enables |
| req_rd | output | 1 | 1 read cycle, 0 write cycle |
| req_ben_n | output | BEN_W (4) | Active-low byte enables |
| req_wdata | output | DATA_W (32) | Write data for the cycle |
| resp_valid | input | 1 | One-cycle completion pulse |
| resp_rdata | input | DATA_W (32) | Returned read data, valid with `resp_valid` |
| irq | output | 1 | Completion interrupt |

## Verification
Register writes take effect on the clock edge that samples `reg_wr`, so the bench reads them back at the following falling edge. `reg_rdata` is combinational and is sampled a short delay after `reg_addr` settles. `req_valid` appears one edge after the start write. Pending, done, the read-data register and `irq` all change on the edge that samples `resp_valid`. The bench therefore polls pending at falling edges and checks done, read data and the captured request only after pending is seen low. Request-field stability under back-pressure and the pending/done exclusivity are checked on every cycle by assertions.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
  // register word indices (byte offset / 4)
  localparam int unsigned WI_ADDR  = 0;
  localparam int unsigned WI_WDATA = 1;
  localparam int unsigned WI_RDATA = 2;
  localparam int unsigned WI_CTRL  = 3;
  localparam int unsigned WI_IEN   = 4;
  localparam int unsigned WI_ICLR  = 5;

  // control/status bit positions
  localparam int unsigned CB_DIR   = 4;
  localparam int unsigned CB_CLR   = 6;
  localparam int unsigned CB_GO    = 7;
  localparam int unsigned CB_DONE  = 8;
  localparam int unsigned CB_PEND  = 9;

  typedef struct packed {
    logic go;
    logic clr_done;
    logic clr_irq;
  } host_evt_t;
endpackage

// File: rtl/ibc_lowaddr.sv
module ibc_lowaddr #(
  parameter int unsigned BEN_W = 4,
  localparam int unsigned LSB_W = $clog2(BEN_W)
) (
  input  logic [BEN_W-1:0] ben_n,
  output logic [LSB_W-1:0] low
);
  logic [BEN_W-1:0] act;
  logic [BEN_W-1:0] run;
  int unsigned      cnt;
  int unsigned      lo;
  logic             found;
  logic             pow2;
  logic             aligned;

  always_comb begin
    act   = ~ben_n;
    cnt   = 0;
    lo    = 0;
    found = 1'b0;
    for (int unsigned i = 0; i < BEN_W; i++) begin
      if (act[i]) begin
        cnt = cnt + 1;
        if (!found) begin
          lo    = i;
          found = 1'b1;
        end
      end
    end
    run = '0;
    for (int unsigned i = 0; i < BEN_W; i++) begin
      if (i >= lo && i < lo + cnt) run[i] = 1'b1;
    end
    pow2    = (cnt != 0) && ((cnt & (cnt - 1)) == 0);
    aligned = (cnt != 0) && ((lo & (cnt - 1)) == 0);
    if (found && pow2 && aligned && (act == run)) low = lo[LSB_W-1:0];
    else                                          low = '0;
  end
endmodule

// File: rtl/ibc_regs.sv
module ibc_regs
  import ibc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RAW    = 5,
  localparam int unsigned BEN_W = DATA_W / 8,
  localparam int unsigned SEL_W = RAW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [BEN_W-1:0]  reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pend,
  input  logic              go_bit,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [BEN_W-1:0]  ben_q,
  output logic              dir_q,
  output logic              ien_q,
  output host_evt_t         evt
);
  logic [SEL_W-1:0] sel;
  logic             wr_free;
  logic             hit_addr, hit_wdata, hit_ctrl, hit_ien, hit_iclr;
  logic [1:0]       unused_lsb;

  assign sel       = reg_addr[RAW-1:2];
  assign unused_lsb = reg_addr[1:0];
  assign wr_free   = reg_wr && !pend;
  assign hit_addr  = sel == SEL_W'(WI_ADDR);
  assign hit_wdata = sel == SEL_W'(WI_WDATA);
  assign hit_ctrl  = sel == SEL_W'(WI_CTRL);
  assign hit_ien   = sel == SEL_W'(WI_IEN);
  assign hit_iclr  = sel == SEL_W'(WI_ICLR);

  // address: whole-word writes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             addr_q <= '0;
    else if (wr_free && hit_addr && &reg_be) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  // write data: per byte lane
  for (genvar b = 0; b < BEN_W; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wdata_q[8*b +: 8] <= '0;
      else if (wr_free && hit_wdata && reg_be[b])
        wdata_q[8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end

  // control fields live in the low byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ben_q <= '0;
      dir_q <= 1'b0;
    end else if (wr_free && hit_ctrl && reg_be[0]) begin
      ben_q <= reg_wdata[BEN_W-1:0];
      dir_q <= reg_wdata[CB_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ien_q <= 1'b0;
    else if (reg_wr && hit_ien && reg_be[0]) ien_q <= reg_wdata[0];
  end

  assign evt.go       = wr_free && hit_ctrl && reg_be[0] && reg_wdata[CB_GO];
  assign evt.clr_done = reg_wr && hit_ctrl && reg_be[0] && reg_wdata[CB_CLR];
  assign evt.clr_irq  = reg_wr && hit_iclr;

  always_comb begin
    reg_rdata = '0;
    if (hit_addr)  reg_rdata = DATA_W'(addr_q);
    if (hit_wdata) reg_rdata = wdata_q;
    if (sel == SEL_W'(WI_RDATA)) reg_rdata = rdata;
    if (hit_ctrl) begin
      reg_rdata[BEN_W-1:0] = ben_q;
      reg_rdata[CB_DIR]    = dir_q;
      reg_rdata[CB_GO]     = go_bit;
      reg_rdata[CB_DONE]   = done;
      reg_rdata[CB_PEND]   = pend;
    end
    if (hit_ien)   reg_rdata[0] = ien_q;
  end
endmodule

// File: rtl/ibc_launch.sv
module ibc_launch
  import ibc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_evt_t         evt,
  input  logic              dir,
  input  logic              req_ready,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_rdata,
  output logic              go_q,
  output logic              pend_q,
  output logic              done_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic finish;

  // completion only counts for a cycle already handed to the engine
  assign finish = resp_valid && pend_q && !go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (evt.go) begin
        go_q   <= 1'b1;
        pend_q <= 1'b1;
      end else begin
        if (go_q && req_ready) go_q   <= 1'b0;
        if (finish)            pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      done_q <= 1'b0;
    else if (finish)                                 done_q <= 1'b1;
    else if (evt.go || evt.clr_done || evt.clr_irq)  done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdata_q <= '0;
    else if (finish && dir)  rdata_q <= resp_rdata;
  end
endmodule

// File: rtl/ibc_ctrl.sv
module ibc_ctrl
  import ibc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RAW    = 5,
  localparam int unsigned BEN_W = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(BEN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [BEN_W-1:0]  reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_rd,
  output logic [BEN_W-1:0]  req_ben_n,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_rdata,
  output logic              irq
);
  host_evt_t         evt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BEN_W-1:0]  ben_q;
  logic              dir_q, ien_q;
  logic              go_q, pend_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic [LSB_W-1:0]  low;
  logic [LSB_W-1:0]  unused_addr_lsb;

  ibc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend(pend_q), .go_bit(go_q), .done(done_q), .rdata(rdata_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .ben_q(ben_q),
    .dir_q(dir_q), .ien_q(ien_q), .evt(evt)
  );

  ibc_launch #(.DATA_W(DATA_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .evt(evt), .dir(dir_q),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .go_q(go_q), .pend_q(pend_q), .done_q(done_q), .rdata_q(rdata_q)
  );

  ibc_lowaddr #(.BEN_W(BEN_W)) u_low (.ben_n(ben_q), .low(low));

  assign unused_addr_lsb = addr_q[LSB_W-1:0];
  assign req_valid = go_q;
  assign req_addr  = {addr_q[ADDR_W-1:LSB_W], low};
  assign req_rd    = dir_q;
  assign req_ben_n = ben_q;
  assign req_wdata = wdata_q;
  assign irq       = done_q && ien_q;
endmodule

// File: rtl/ibc_ctrl_chk.sv
module ibc_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned BEN_W = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(BEN_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_rd,
  input logic [BEN_W-1:0]  req_ben_n,
  input logic              resp_valid,
  input logic              pend,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_rd) && $stable(req_ben_n)); // R5
  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R5
  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pend); // R9
  AST_PEND_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && done)); // R6
  AST_DONE_FROM_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(resp_valid)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(resp_valid) |-> $stable(rdata)); // R8
  AST_WORD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_ben_n == '0) |-> req_addr[LSB_W-1:0] == '0); // R3
endmodule

bind ibc_ctrl ibc_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_rd(req_rd), .req_ben_n(req_ben_n),
  .resp_valid(resp_valid), .pend(pend_q), .done(done_q), .rdata(rdata_q)
);

// File: tb/test_ibc_ctrl.sv
`timescale 1ns/1ps
module test_ibc_ctrl;
  localparam logic [4:0] A_ADDR = 5'h00, A_WD = 5'h04, A_RD = 5'h08,
                         A_CTL = 5'h0C, A_IEN = 5'h10, A_ICL = 5'h14;

  typedef struct packed {
    logic        rd;
    logic [31:0] addr;
    logic [3:0]  ben;
    logic [1:0]  low;
    logic [31:0] data;   // write data, or expected read data
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 32'h10, 4'h0, 2'd0, 32'hA1B2C3D4},
    '{1'b0, 32'h10, 4'hE, 2'd0, 32'h000000EE},
    '{1'b0, 32'h13, 4'h7, 2'd3, 32'h55000000},
    '{1'b1, 32'h10, 4'h0, 2'd0, 32'h55B2C3EE},
    '{1'b0, 32'h20, 4'h3, 2'd2, 32'h12340000},
    '{1'b1, 32'h22, 4'hC, 2'd0, 32'h12340000},
    '{1'b1, 32'h11, 4'hD, 2'd1, 32'h55B2C3EE},
    '{1'b0, 32'h30, 4'hA, 2'd0, 32'hFFFFFFFF},
    '{1'b1, 32'h30, 4'h0, 2'd0, 32'h00FF00FF},
    '{1'b1, 32'h30, 4'h9, 2'd0, 32'h00FF00FF},
    '{1'b1, 32'h30, 4'hB, 2'd2, 32'h00FF00FF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_rd, irq;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_ben_n;
  logic        resp_valid = 1'b0;
  logic [31:0] resp_rdata = 32'hDEAD_BEEF;

  int checks = 0;
  int fails  = 0;

  // engine model state
  bit          ready_cfg = 1'b1;
  bit          inject = 1'b0;
  int          hs_cnt = 0;
  logic [31:0] cap_addr, cap_data;
  logic        cap_rd;
  logic [3:0]  cap_ben;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  ibc_ctrl i_ibc_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_rd(req_rd), .req_ben_n(req_ben_n), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .irq(irq)
  );

  // external-cycle engine with a small word memory
  initial begin : engine
    bit acc = 1'b0;
    bit busy = 1'b0;
    int cnt = 0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (resp_valid) begin
        resp_valid = 1'b0;
        resp_rdata = 32'hDEAD_BEEF;
      end
      if (inject) begin
        inject = 1'b0;
        resp_valid = 1'b1;
        resp_rdata = 32'hBAD0_BAD0;
      end else if (acc) begin
        acc = 1'b0; busy = 1'b1; cnt = 2; req_ready = 1'b0;
      end else if (busy) begin
        if (cnt == 0) begin
          busy = 1'b0;
          resp_valid = 1'b1;
          resp_rdata = cap_data;
        end else cnt--;
      end else begin
        req_ready = ready_cfg;
        if (req_valid && req_ready) begin
          hs_cnt++;
          cap_addr = req_addr; cap_rd = req_rd; cap_ben = req_ben_n;
          if (req_rd) cap_data = mem[req_addr[5:2]];
          else begin
            for (int b = 0; b < 4; b++)
              if (!req_ben_n[b]) mem[req_addr[5:2]][8*b +: 8] = req_wdata[8*b +: 8];
            cap_data = 32'h0;
          end
          acc = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 100; k++) begin
      rd(A_CTL, v);
      if (!v[9]) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 req_valid reset", {31'b0, req_valid}, 32'h0);

    // R2 address register full-word only
    wr(A_ADDR, 32'h11223344, 4'hF);
    rd(A_ADDR, v); chk("R2 full write", v, 32'h11223344);
    wr(A_ADDR, 32'hAAAAAAAA, 4'h3);
    rd(A_ADDR, v); chk("R2 partial write ignored", v, 32'h11223344);

    // vector table: R3 R4 R6 R8
    foreach (VECS[i]) begin
      h0 = hs_cnt;
      wr(A_ADDR, VECS[i].addr, 4'hF);
      if (!VECS[i].rd) wr(A_WD, VECS[i].data, 4'hF);
      wr(A_CTL, 32'h80 | (VECS[i].rd ? 32'h10 : 32'h0) | {28'b0, VECS[i].ben}, 4'h1);
      wait_idle();
      chk("R3 request address", cap_addr, {VECS[i].addr[31:2], VECS[i].low});
      chk("R4 direction", {31'b0, cap_rd}, {31'b0, VECS[i].rd});
      chk("R4 byte enables", {28'b0, cap_ben}, {28'b0, VECS[i].ben});
      chk("R5 one handshake", hs_cnt - h0, 1);
      rd(A_CTL, v);
      chk("R6 done set pending clear", {30'b0, v[9:8]}, 32'h1);
      if (VECS[i].rd) begin
        rd(A_RD, v); chk("R8 read capture", v, VECS[i].data);
      end
    end

    // R10 interrupt gating
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h1, 4'h1);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);

    // R7 clear via bit 6
    wr(A_CTL, 32'h40, 4'h1);
    rd(A_CTL, v); chk("R7 clear bit", {30'b0, v[9:8]}, 32'h0);
    chk("R7 irq after clear", {31'b0, irq}, 32'h0);

    // R8 write cycle keeps read data
    wr(A_CTL, 32'h80, 4'h1);
    wait_idle();
    rd(A_RD, v); chk("R8 write leaves read data", v, 32'h00FF00FF);
    chk("R10 irq on done", {31'b0, irq}, 32'h1);
    wr(A_ICL, 32'h0, 4'h0);
    rd(A_CTL, v); chk("R7 interrupt clear register", {31'b0, v[8]}, 32'h0);

    // R5 R7 R9 back-pressure and blocked writes
    wr(A_CTL, 32'h80, 4'h1);
    wait_idle();
    ready_cfg = 1'b0;
    h0 = hs_cnt;
    @(negedge clk);
    wr(A_ADDR, 32'h40, 4'hF);
    wr(A_CTL, 32'h80, 4'h1);
    rd(A_CTL, v);
    chk("R7 start clears done", {31'b0, v[8]}, 32'h0);
    chk("R5 start and pending set", {22'b0, v[9], 1'b0, v[7], 7'b0}, 32'h280);
    chk("R5 req_valid raised", {31'b0, req_valid}, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_CTL, v); chk("R5 start held under back-pressure", {31'b0, v[7]}, 32'h1);
    wr(A_ADDR, 32'h777, 4'hF);
    rd(A_ADDR, v); chk("R9 address write ignored", v, 32'h40);
    wr(A_CTL, 32'h9F, 4'h1);
    rd(A_CTL, v); chk("R9 control write ignored", {27'b0, v[4:0]}, 32'h0);
    ready_cfg = 1'b1;
    wait_idle();
    chk("R9 single launch", hs_cnt - h0, 1);
    rd(A_CTL, v); chk("R5 start self-cleared", {22'b0, v[9:8], v[7:0]}, 32'h100);

    // R11 stray completion
    wr(A_CTL, 32'h40, 4'h1);
    inject = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_CTL, v); chk("R11 stray completion ignored", {31'b0, v[8]}, 32'h0);
    rd(A_RD, v);  chk("R11 read data unchanged", v, 32'h00FF00FF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule